// File: doc/BRIEF.md
# Overcurrent Fault Supervisor Latch

This block sits between the digitised overcurrent comparator of a three-phase bridge driver and its six gate channels. A trip has to stay high for a whole blanking window before it counts. Once it counts, the block latches a shutdown. After a fixed number of cycles it raises one global disable that forces all six gate outputs off together. After a separate count it pulls the active-low fault line. A low-side undervoltage flag drives the same two outputs directly, for as long as the flag is high, without latching anything.

The latched shutdown is released only by a qualified clear sequence. The monitored PWM commands (active low, so a 1 means "off") must all sit in their off state with the trip input low. This must hold for a long, unbroken run of cycles. By default only the three low-side commands are monitored; a parameter extends the rule to all six. Reset leaves the block latched and fully asserted, so the bridge stays off until a clean clear sequence has been seen.

Top module: `ocp_fault_supervisor`

## Requirements
- R1: While reset is held, and from the first clock edge after reset onward, `gate_off_o` is 1 and `fault_n_o` is 0. Both stay that way until a clear sequence (R6) has completed.
- R2: A trip is accepted only when `trip_i` has been sampled high on BLANK_CYC (default 80) consecutive rising edges. The acceptance takes effect at the last of those edges. A high run one edge shorter leaves both outputs unchanged.
- R3: `gate_off_o` rises OFF_DLY_CYC (default 52) rising edges after the accepting edge, and then stays high while the shutdown is latched.
- R4: `fault_n_o` falls FLT_DLY_CYC (default 30) rising edges after the accepting edge, and then stays low while the shutdown is latched.
- R5: While `uv_i` is 1, `gate_off_o` is 1 and `fault_n_o` is 0 in the same cycle, with no clock edge needed. When `uv_i` returns to 0, the outputs go back to what the latch state alone gives, and no state is left behind.
- R6: The clear condition is: `trip_i` is 0, and every monitored bit of `pwm_n_i` is 1. The low-side commands are bits [5:3] and the high-side commands are bits [2:0]. Once the clear condition has been sampled on CLR_CYC (default 1700) consecutive rising edges while latched, the latch releases at that last edge. Both outputs then go inactive unless `uv_i` is 1.
- R7: A monitored `pwm_n_i` bit sampled at 0 restarts the clear count from zero.
- R8: `trip_i` sampled at 1 while latched restarts the clear count from zero, even if the high run is too short to be accepted.
- R9: With CLR_ALL_SIX = 0 (default), bits [2:0] of `pwm_n_i` have no effect on the clear timing. With CLR_ALL_SIX = 1, all six bits are monitored.
- R10: A further trip accepted while the shutdown is already latched does not restart the R3 or R4 delays. The outputs stay asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Digitised overcurrent comparator, 1 = overcurrent |
| uv_i | input | 1 | Low-side undervoltage flag, 1 = undervoltage |
| pwm_n_i | input | 6 | Active-low gate commands; [2:0] high side, [5:3] low side |
| gate_off_o | output | 1 | Global disable for all six gate outputs, 1 = force off |
| fault_n_o | output | 1 | Fault indication, 0 = fault |

## Verification
The register results are due at fixed edges. Acceptance takes effect at the BLANK_CYC-th consecutive high sample. The disable is due OFF_DLY_CYC edges later and the fault FLT_DLY_CYC edges later. Release happens at the CLR_CYC-th consecutive clean sample. The undervoltage path has no edge in it at all. The bench drives inputs just after each falling edge and compares one nanosecond later, before the next rising edge. It uses a bench model that predicts the state after the coming edge from the inputs it has just applied, so every expected value lands on exactly the cycle the requirements name.

// File: rtl/ocp_sup_pkg.sv
// Shared constants and helpers for the overcurrent fault supervisor.
// Assumes six active-low gate commands, high side in the low three bits.
package ocp_sup_pkg;

    localparam int PWM_W  = 6;
    localparam int PHASES = 3;
    localparam int LS_LSB = 3;

    // Bits needed to hold values 0..limit
    function automatic int cnt_bits(input int limit);
        int w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/ocp_trip_blank.sv
// Trip blanking filter: counts consecutive high samples of the trip input
// and emits a one-cycle accept when the BLANK_CYC-th high sample is seen.
// Assumes trip_i is already synchronous to clk and BLANK_CYC >= 1.
module ocp_trip_blank #(
    parameter int BLANK_CYC = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    output logic accept_o
);
    localparam int CW = ocp_sup_pkg::cnt_bits(BLANK_CYC);
    localparam logic [CW-1:0] RUN_MAX = CW'(BLANK_CYC);
    localparam logic [CW-1:0] RUN_HIT = CW'(BLANK_CYC - 1);

    logic [CW-1:0] run_q;

    // Length of the current high run of trip_i, saturating at BLANK_CYC
    always_ff @(posedge clk) begin
        if (!rst_n || !trip_i) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Accept exactly on the sample that completes the blanking window
    assign accept_o = trip_i && (run_q == RUN_HIT);

endmodule

// File: rtl/ocp_clear_timer.sv
// Clear qualifier: while the shutdown is armed, counts consecutive cycles
// in which trip is low and every monitored gate command is off (1).
// Emits a one-cycle clear when CLR_CYC such cycles have been sampled.
// Assumes CLR_CYC >= 1; CLR_ALL_SIX picks low-side-only or all six commands.
module ocp_clear_timer #(
    parameter int CLR_CYC     = 1700,
    parameter bit CLR_ALL_SIX = 1'b0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           armed_i,
    input  logic                           trip_i,
    input  logic [ocp_sup_pkg::PWM_W-1:0]  pwm_n_i,
    output logic                           clear_o
);
    import ocp_sup_pkg::*;

    localparam int CW = cnt_bits(CLR_CYC);
    localparam logic [CW-1:0] QUIET_MAX = CW'(CLR_CYC);
    localparam logic [CW-1:0] QUIET_HIT = CW'(CLR_CYC - 1);

    logic [PWM_W-1:0] watch_mask;
    logic             quiet;
    logic [CW-1:0]    quiet_q;

    // Select which commands must be off for the clear to count
    generate
        if (CLR_ALL_SIX) begin : g_all_six
            assign watch_mask = '1;
        end else begin : g_low_side
            assign watch_mask = {{PHASES{1'b1}}, {LS_LSB{1'b0}}};
        end
    endgenerate

    assign quiet = !trip_i && ((pwm_n_i & watch_mask) == watch_mask);

    // Consecutive quiet cycles while armed; any disturbance restarts it
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_i || !quiet) begin
            quiet_q <= '0;
        end else if (quiet_q != QUIET_MAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // Release on the sample that completes the quiet interval
    assign clear_o = armed_i && quiet && (quiet_q == QUIET_HIT);

endmodule

// File: rtl/ocp_fault_latch.sv
// Shutdown latch with output staging: holds the latched fault, times the
// disable and fault indications from the accepting edge, and merges in the
// unlatched undervoltage condition. Reset leaves the latch set with both
// indications already asserted. Assumes OFF_DLY_CYC, FLT_DLY_CYC >= 1.
module ocp_fault_latch #(
    parameter int OFF_DLY_CYC = 52,
    parameter int FLT_DLY_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic clear_i,
    input  logic uv_i,
    output logic latched_o,
    output logic gate_off_o,
    output logic fault_n_o
);
    localparam int DLY_MAX = (OFF_DLY_CYC > FLT_DLY_CYC) ? OFF_DLY_CYC : FLT_DLY_CYC;
    localparam int DW = ocp_sup_pkg::cnt_bits(DLY_MAX);
    localparam logic [DW-1:0] AGE_MAX = DW'(DLY_MAX);
    localparam logic [DW-1:0] AGE_OFF = DW'(OFF_DLY_CYC);
    localparam logic [DW-1:0] AGE_FLT = DW'(FLT_DLY_CYC);

    logic          latched_q;
    logic [DW-1:0] age_q;
    logic          off_due;
    logic          flt_due;

    // Latch state and age since acceptance; a new accept while latched is ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched_q <= 1'b1;
            age_q     <= AGE_MAX;
        end else if (latched_q) begin
            if (clear_i) begin
                latched_q <= 1'b0;
            end
            if (age_q != AGE_MAX) begin
                age_q <= age_q + 1'b1;
            end
        end else if (accept_i) begin
            latched_q <= 1'b1;
            age_q     <= '0;
        end
    end

    assign off_due = latched_q && (age_q >= AGE_OFF);
    assign flt_due = latched_q && (age_q >= AGE_FLT);

    assign latched_o  = latched_q;
    assign gate_off_o = uv_i || off_due;
    assign fault_n_o  = !(uv_i || flt_due);

endmodule

// File: rtl/ocp_fault_supervisor.sv
// Overcurrent fault supervisor: blanks the trip input, latches an accepted
// trip into a global gate disable and an active-low fault, releases only
// after a qualified quiet interval on the gate commands, and passes
// undervoltage straight through. Assumes all inputs synchronous to clk.
module ocp_fault_supervisor #(
    parameter int BLANK_CYC   = 80,
    parameter int OFF_DLY_CYC = 52,
    parameter int FLT_DLY_CYC = 30,
    parameter int CLR_CYC     = 1700,
    parameter bit CLR_ALL_SIX = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_i,
    input  logic       uv_i,
    input  logic [5:0] pwm_n_i,
    output logic       gate_off_o,
    output logic       fault_n_o
);
    logic trip_accept;
    logic clear_pulse;
    logic shut_latched;

    ocp_trip_blank #(
        .BLANK_CYC(BLANK_CYC)
    ) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_i   (trip_i),
        .accept_o (trip_accept)
    );

    ocp_clear_timer #(
        .CLR_CYC    (CLR_CYC),
        .CLR_ALL_SIX(CLR_ALL_SIX)
    ) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_i (shut_latched),
        .trip_i  (trip_i),
        .pwm_n_i (pwm_n_i),
        .clear_o (clear_pulse)
    );

    ocp_fault_latch #(
        .OFF_DLY_CYC(OFF_DLY_CYC),
        .FLT_DLY_CYC(FLT_DLY_CYC)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (trip_accept),
        .clear_i    (clear_pulse),
        .uv_i       (uv_i),
        .latched_o  (shut_latched),
        .gate_off_o (gate_off_o),
        .fault_n_o  (fault_n_o)
    );

endmodule

// File: rtl/ocp_fault_supervisor_chk.sv
// Property checker for the overcurrent fault supervisor, bound to the top.
// Relates the blanking, clear and latch stages to each other and to the ports.
module ocp_fault_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic trip_i,
    input logic uv_i,
    input logic accept,
    input logic clear,
    input logic latched,
    input logic gate_off_o,
    input logic fault_n_o
);
    // R5
    uv_forces_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |-> (gate_off_o && !fault_n_o));

    // R6
    clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !latched);

    // R8
    clear_needs_trip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !trip_i);

    // R2
    latch_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(accept));

    // R3
    disable_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off_o |-> (latched || uv_i));

    // R4
    fault_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n_o |-> (latched || uv_i));

    // R6
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!latched && !uv_i) |-> (!gate_off_o && fault_n_o));

endmodule

bind ocp_fault_supervisor ocp_fault_supervisor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_i     (trip_i),
    .uv_i       (uv_i),
    .accept     (trip_accept),
    .clear      (clear_pulse),
    .latched    (shut_latched),
    .gate_off_o (gate_off_o),
    .fault_n_o  (fault_n_o)
);

// File: tb/ocp_fault_supervisor_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random stimulus, checked every
// cycle against a requirement-level model of the expected outputs.
module ocp_fault_supervisor_test;
    localparam int BLANK = 80;
    localparam int OFFD  = 52;
    localparam int FLTD  = 30;
    localparam int CLR   = 1700;
    localparam int AMAX  = (OFFD > FLTD) ? OFFD : FLTD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trip_i = 1'b0;
    logic       uv_i = 1'b0;
    logic [5:0] pwm_n_i = 6'h3F;
    logic       gate_off_o;
    logic       fault_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: latch, age since accept, trip run length, quiet run length
    int m_lat = 1, m_age = AMAX, m_run = 0, m_quiet = 0;
    int rlen = 0;

    always #2.5 clk = ~clk;

    ocp_fault_supervisor uut (
        .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .uv_i(uv_i),
        .pwm_n_i(pwm_n_i), .gate_off_o(gate_off_o), .fault_n_o(fault_n_o)
    );

    function automatic logic exp_off(input int lat, input int age, input logic uv);
        return uv || (lat != 0 && age >= OFFD);
    endfunction

    function automatic logic exp_fault_n(input int lat, input int age, input logic uv);
        return !(uv || (lat != 0 && age >= FLTD));
    endfunction

    // Advance the model across the coming rising edge using current inputs
    task automatic model_step();
        bit accept, quiet;
        accept = trip_i && (m_run == BLANK - 1);
        m_run  = trip_i ? ((m_run < BLANK) ? m_run + 1 : m_run) : 0;
        quiet  = !trip_i && (pwm_n_i[5:3] == 3'b111);
        if (!rst_n) begin
            m_lat = 1; m_age = AMAX; m_run = 0; m_quiet = 0;
        end else if (m_lat != 0) begin
            if (quiet && m_quiet == CLR - 1) m_lat = 0;
            m_quiet = quiet ? m_quiet + 1 : 0;
            if (m_age < AMAX) m_age++;
        end else begin
            m_quiet = 0;
            if (accept) begin m_lat = 1; m_age = 0; end
        end
    endtask

    task automatic check(input string tag);
        logic eo, ef;
        eo = exp_off(m_lat, m_age, uv_i);
        ef = exp_fault_n(m_lat, m_age, uv_i);
        checks++;
        if (gate_off_o !== eo || fault_n_o !== ef) begin
            errors++;
            $display("FAIL %s t=%0t: gate_off=%b fault_n=%b expected gate_off=%b fault_n=%b",
                     tag, $time, gate_off_o, fault_n_o, eo, ef);
        end
    endtask

    // mode 0: hold inputs; 1: random everything; 2: random high-side bits only
    task automatic run(input int n, input string tag, input int mode);
        for (int i = 0; i < n; i++) begin
            if (mode == 1) begin
                if (rlen == 0) begin
                    trip_i = $urandom_range(0, 2) == 0;
                    rlen = $urandom_range(1, 130);
                end
                rlen--;
                uv_i = $urandom_range(0, 199) == 0;
                pwm_n_i = ($urandom_range(0, 299) == 0) ? 6'($urandom) : 6'h3F;
            end else if (mode == 2) begin
                pwm_n_i = {3'b111, 3'($urandom)};
            end
            #1;
            check(tag);
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic latch_trip();
        trip_i = 1'b1; run(BLANK + AMAX + 2, "R3 R4", 0);
        trip_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE));
        @(negedge clk);
        // R1: faulted during and after reset until a clean clear
        run(6, "R1", 0);
        rst_n = 1'b1;
        run(20, "R1", 0);
        run(CLR, "R6", 0);
        // R2: one cycle short of the blanking window, then exact window
        trip_i = 1'b1; run(BLANK - 1, "R2", 0);
        trip_i = 1'b0; run(30, "R2", 0);
        // R3 R4: accepted trip, staged disable and fault
        latch_trip();
        // R10: a second long trip while latched
        run(10, "R10", 0);
        trip_i = 1'b1; run(BLANK + 20, "R10", 0);
        trip_i = 1'b0;
        // R7: low-side command breaks the quiet interval
        run(1000, "R7", 0);
        pwm_n_i = 6'b101111; run(3, "R7", 0);
        pwm_n_i = 6'h3F; run(CLR + 5, "R7", 0);
        // R9: high-side commands toggling do not delay the clear
        latch_trip();
        run(CLR + 5, "R9", 2);
        pwm_n_i = 6'h3F;
        // R8: short trip inside the quiet interval restarts it
        latch_trip();
        run(500, "R8", 0);
        trip_i = 1'b1; run(5, "R8", 0);
        trip_i = 1'b0; run(CLR + 5, "R8", 0);
        // R5: undervoltage, idle and latched
        uv_i = 1'b1; run(4, "R5", 0);
        uv_i = 1'b0; run(4, "R5", 0);
        latch_trip();
        uv_i = 1'b1; run(4, "R5", 0);
        uv_i = 1'b0; run(CLR + 5, "R5", 0);
        // mixed random traffic
        run(60000, "R2 R3 R4 R5 R6 R7 R8", 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule